// File: doc/BRIEF.md
# One-Shot Match Timer

This block is a free-standing timer that software controls over a word-wide register port. The port has separate read and write strobes, a byte address and 32-bit data. Writing a target value to the match register arms a one-shot count. From then on the counter advances by one on every cycle in which `tick_en` is high, and it stops as soon as it equals the target. The counter wraps from all ones to zero on the way when it has to. The moment the counter lands on the target is the hit. At the hit the block can latch a pending flag and drive a level interrupt, provided software has left a nonzero value in the interrupt-enable register.

The counting side is a state machine with two states. `CNT_IDLE` holds the counter still. `CNT_RUN` advances it on ticks. Its transitions are ARM (any match write, from either state, into `CNT_RUN`) and HIT (the tick that makes the counter equal the target, from `CNT_RUN` to `CNT_IDLE`). The interrupt side is a second two-state machine. `IRQ_IDLE` moves to `IRQ_PEND` on TAKE, which is a hit while the enable register is nonzero. `IRQ_PEND` returns to `IRQ_IDLE` on ACK, which is a write to the status register in a cycle with no TAKE. The interrupt output is high exactly in `IRQ_PEND`.

`tick_en` stands in for the nominal 50 MHz count clock. The counter width is a parameter (`CNT_W`, at most `DATA_W`), and reads return the counter zero-extended. Only whole aligned words are decoded.

Top module: `oneshot_match_timer`

## Requirements
- R1: After reset, reads of the counter (0x10), status (0x14) and enable (0x1c) registers return 0, `irq` is low and the counter is idle.
- R2: A read presents its data on `rdata` in the cycle after `rd_en`, and `rdata` is 0 in any cycle that follows no read. The counter is at 0x10, the status flag at 0x14 bit 0 and the enable word at 0x1c. Every other address reads 0, including 0x00 and unaligned addresses such as 0x11.
- R3: A write to 0x00 stores the low `CNT_W` bits of `wdata` as the target and enters `CNT_RUN`. While running, each cycle with `tick_en` high adds one to the counter. In the cycle of a match write the counter does not advance, even if `tick_en` is high.
- R4: The counter wraps from all ones to zero. A target at or below the counter is reached after passing through all ones. A target equal to the counter takes 2^`CNT_W` ticks.
- R5: On the tick that makes the counter equal the target, the counter stops at the target. Later ticks change nothing until the next match write.
- R6: A hit sets the status flag and `irq` at the same clock edge if the enable register is nonzero. With the enable register at zero, a hit leaves status and `irq` unchanged. If the enable register is written in the same cycle as a hit, the value it held before that write decides.
- R7: `irq` is a level equal to the status flag. It stays high until cleared, and rewriting the enable register does not drop it.
- R8: Any write to 0x14 clears the status flag and `irq` at the next edge, whatever the data. A hit in the same cycle wins and the flag stays set.
- R9: Writes to 0x10 and to undefined addresses change no state. A write to 0x1c stores all 32 bits.
- R10: A match write while running replaces the target, and counting continues from the present counter value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| tick_en | input | 1 | Count enable; one increment per high cycle while running |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Level interrupt, equal to the status flag |

## Verification
Every result of this block appears one edge after its stimulus. Read data, a counter step, the counter halting on a hit, the status flag rising with `irq`, and a clear all change at the clock edge that samples the strobes or the tick. The bench drives each stimulus half a cycle before that edge. It advances its requirement model at the edge, then compares `irq` and `rdata` at the next falling edge, before any new input is applied. The bench uses an 8-bit counter so that the wrap and equal-target cases finish within the run.

// File: rtl/omt_pkg.sv
package omt_pkg;

    typedef enum logic {
        CNT_IDLE = 1'b0,
        CNT_RUN  = 1'b1
    } cnt_state_e;

    typedef enum logic {
        IRQ_IDLE = 1'b0,
        IRQ_PEND = 1'b1
    } irq_state_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MATCH,
        SEL_COUNT,
        SEL_STATUS,
        SEL_IEN
    } reg_sel_e;

    localparam int unsigned OFS_MATCH  = 32'h00;
    localparam int unsigned OFS_COUNT  = 32'h10;
    localparam int unsigned OFS_STATUS = 32'h14;
    localparam int unsigned OFS_IEN    = 32'h1c;

endpackage

// File: rtl/omt_decode.sv
module omt_decode
    import omt_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    always_comb begin
        if (addr == ADDR_W'(OFS_MATCH)) begin
            sel = SEL_MATCH;
        end else if (addr == ADDR_W'(OFS_COUNT)) begin
            sel = SEL_COUNT;
        end else if (addr == ADDR_W'(OFS_STATUS)) begin
            sel = SEL_STATUS;
        end else if (addr == ADDR_W'(OFS_IEN)) begin
            sel = SEL_IEN;
        end else begin
            sel = SEL_NONE;
        end
    end

endmodule

// File: rtl/omt_counter.sv
module omt_counter
    import omt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             arm,
    input  logic [CNT_W-1:0] arm_val,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] match,
    output logic             running,
    output logic             hit
);

    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q, match_q, count_inc;
    logic             advance;

    assign count_inc = count_q + CNT_W'(1);
    assign advance   = (state_q == CNT_RUN) && tick_en && !arm;
    assign hit       = advance && (count_inc == match_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CNT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: ARM (any state -> RUN), HIT (RUN -> IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_IDLE: begin
                if (arm) state_d = CNT_RUN;
            end
            CNT_RUN: begin
                if (arm) begin
                    state_d = CNT_RUN;
                end else if (hit) begin
                    state_d = CNT_IDLE;
                end
            end
            default: state_d = CNT_IDLE;
        endcase
    end

    // target and counter datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            match_q <= '0;
        end else begin
            if (arm) begin
                match_q <= arm_val;
            end
            if (advance) begin
                count_q <= count_inc;
            end
        end
    end

    // outputs
    always_comb begin
        running = (state_q == CNT_RUN);
        count   = count_q;
        match   = match_q;
    end

endmodule

// File: rtl/omt_irq_ctrl.sv
module omt_irq_ctrl
    import omt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              clr,
    input  logic              ien_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ien,
    output logic              status,
    output logic              irq
);

    irq_state_e        state_q, state_d;
    logic [DATA_W-1:0] ien_q;
    logic              take;

    assign take = hit && (ien_q != '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: TAKE (IDLE -> PEND), ACK (PEND -> IDLE, loses to TAKE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: begin
                if (take) state_d = IRQ_PEND;
            end
            IRQ_PEND: begin
                if (clr && !take) state_d = IRQ_IDLE;
            end
            default: state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q <= '0;
        end else if (ien_wr) begin
            ien_q <= wdata;
        end
    end

    // outputs
    always_comb begin
        status = (state_q == IRQ_PEND);
        irq    = (state_q == IRQ_PEND);
        ien    = ien_q;
    end

endmodule

// File: rtl/oneshot_match_timer.sv
module oneshot_match_timer
    import omt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    reg_sel_e          sel;
    logic              arm_wr, stat_clr, ien_wr;
    logic [CNT_W-1:0]  count, match;
    logic              running, hit, status;
    logic [DATA_W-1:0] ien, rd_count, rd_val, rdata_q;

    omt_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (addr),
        .sel  (sel)
    );

    assign arm_wr   = wr_en && (sel == SEL_MATCH);
    assign stat_clr = wr_en && (sel == SEL_STATUS);
    assign ien_wr   = wr_en && (sel == SEL_IEN);

    omt_counter #(.CNT_W(CNT_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .arm     (arm_wr),
        .arm_val (wdata[CNT_W-1:0]),
        .count   (count),
        .match   (match),
        .running (running),
        .hit     (hit)
    );

    omt_irq_ctrl #(.DATA_W(DATA_W)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (hit),
        .clr    (stat_clr),
        .ien_wr (ien_wr),
        .wdata  (wdata),
        .ien    (ien),
        .status (status),
        .irq    (irq)
    );

    generate
        if (CNT_W < DATA_W) begin : g_ext
            assign rd_count = {{(DATA_W-CNT_W){1'b0}}, count};
        end else begin : g_full
            assign rd_count = count;
        end
    endgenerate

    always_comb begin
        unique case (sel)
            SEL_COUNT:  rd_val = rd_count;
            SEL_STATUS: rd_val = DATA_W'(status);
            SEL_IEN:    rd_val = ien;
            default:    rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            rdata_q <= rd_val;
        end else begin
            rdata_q <= '0;
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/omt_checker.sv
module omt_checker #(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              arm,
    input logic              stat_clr,
    input logic              running,
    input logic              hit,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  match,
    input logic [DATA_W-1:0] ien,
    input logic              irq
);

    // R3
    step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick_en && !arm) |=> (count == $past(count) + CNT_W'(1)));

    // R5
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !arm) |=> $stable(count));

    // R5
    stop_on_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (!running && (count == $past(match))));

    // R6
    gated_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && (ien == '0) && !irq) |=> !irq);

    // R6
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(hit) && $past(tick_en)));

    // R7
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !stat_clr) |=> irq);

    // R8
    clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(stat_clr));

endmodule

bind oneshot_match_timer omt_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .arm      (arm_wr),
    .stat_clr (stat_clr),
    .running  (running),
    .hit      (hit),
    .count    (count),
    .match    (match),
    .ien      (ien),
    .irq      (irq)
);

// File: tb/tb_oneshot_match_timer.sv
module tb_oneshot_match_timer;

    localparam int CW = 8;
    localparam logic [31:0] MASK = 32'((64'd1 << CW) - 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] m_match = '0, m_cnt = '0, m_ien = '0, m_rd = '0;
    logic        m_run = 1'b0, m_stat = 1'b0;

    always #4 clk = ~clk;

    oneshot_match_timer #(.ADDR_W(8), .DATA_W(32), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    function automatic logic [31:0] read_val(input logic [7:0] a);
        case (a)
            8'h10:   return m_cnt;
            8'h14:   return {31'b0, m_stat};
            8'h1c:   return m_ien;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // advance the requirement model over one clock edge
    task automatic model(input logic wr, input logic rd, input logic [7:0] a,
                         input logic [31:0] d, input logic tk);
        logic arm, hit;
        logic [31:0] nxt, old_ien;
        arm     = wr && (a == 8'h00);
        nxt     = (m_cnt + 32'd1) & MASK;
        hit     = m_run && tk && !arm && (nxt == m_match);
        old_ien = m_ien;
        m_rd    = rd ? read_val(a) : 32'h0;
        if (arm) begin
            m_match = d & MASK;
            m_run   = 1'b1;
        end else if (m_run && tk) begin
            m_cnt = nxt;
            if (hit) m_run = 1'b0;
        end
        if (hit && old_ien != 0) m_stat = 1'b1;
        else if (wr && a == 8'h14) m_stat = 1'b0;
        if (wr && a == 8'h1c) m_ien = d;
    endtask

    // drive at the falling edge, compare at the following falling edge
    task automatic step(input logic wr, input logic rd, input logic [7:0] a,
                        input logic [31:0] d, input logic tk, input string tag);
        wr_en = wr; rd_en = rd; addr = a; wdata = d; tick_en = tk;
        @(posedge clk);
        model(wr, rd, a, d, tk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; tick_en = 1'b0;
        chk(tag, "irq", {31'b0, irq}, {31'b0, m_stat});
        chk(tag, "rdata", rdata, m_rd);
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        step(1'b0, 1'b1, a, 32'h0, 1'b0, tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
        step(1'b1, 1'b0, a, d, 1'b0, tag);
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00, 32'h0, 1'b1, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] addrs [7];
        addrs = '{8'h00, 8'h04, 8'h10, 8'h14, 8'h18, 8'h1c, 8'h11};
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h10, "R1");
        rd(8'h14, "R1");
        rd(8'h1c, "R1");

        // R9 writes to counter / undefined offsets ignored
        wr(8'h10, 32'h55, "R9");
        wr(8'h04, 32'hFF, "R9");
        rd(8'h10, "R9");
        ticks(3, "R9");
        rd(8'h10, "R9");
        wr(8'h1c, 32'h8000_0001, "R9");
        rd(8'h1c, "R9");

        // R3 arm and count; tick in arm cycle ignored
        step(1'b1, 1'b0, 8'h00, 32'hABCD_0005, 1'b1, "R3");
        rd(8'h10, "R3");
        for (int i = 0; i < 4; i++) begin
            ticks(1, "R3");
            rd(8'h10, "R3");
        end
        // R5 R6 hit with enable set
        ticks(1, "R6");
        rd(8'h10, "R5");
        rd(8'h14, "R6");
        ticks(5, "R5");
        rd(8'h10, "R5");
        // R7 enable change does not drop irq
        wr(8'h1c, 32'h0, "R7");
        rd(8'h14, "R7");
        // R8 clear with nonzero data
        wr(8'h14, 32'hDEAD, "R8");
        rd(8'h14, "R8");
        // R2 read map corners
        rd(8'h00, "R2");
        rd(8'h11, "R2");

        // R6 gated hit
        wr(8'h00, 32'h8, "R6");
        ticks(3, "R6");
        rd(8'h10, "R6");
        rd(8'h14, "R6");

        // R4 wrap through all ones
        wr(8'h1c, 32'h3, "R4");
        wr(8'h00, 32'h2, "R4");
        ticks(247, "R4");
        rd(8'h10, "R4");
        ticks(3, "R4");
        rd(8'h10, "R4");

        // R8 hit and clear in one cycle: hit wins
        wr(8'h00, 32'h4, "R8");
        ticks(1, "R8");
        step(1'b1, 1'b0, 8'h14, 32'h0, 1'b1, "R8");
        rd(8'h14, "R8");
        wr(8'h14, 32'h0, "R8");

        // R4 target equal to counter takes full period
        wr(8'h00, 32'h4, "R4");
        ticks(255, "R4");
        rd(8'h14, "R4");
        ticks(1, "R4");
        rd(8'h10, "R4");
        wr(8'h14, 32'h0, "R4");

        // R10 re-arm while running
        wr(8'h00, 32'h40, "R10");
        ticks(10, "R10");
        wr(8'h00, 32'h10, "R10");
        rd(8'h10, "R10");
        ticks(2, "R10");
        rd(8'h10, "R10");
        rd(8'h14, "R10");

        // R6 enable written in hit cycle: old value decides
        wr(8'h14, 32'h0, "R6");
        wr(8'h1c, 32'h0, "R6");
        wr(8'h00, 32'h11, "R6");
        step(1'b1, 1'b0, 8'h1c, 32'h1, 1'b1, "R6");
        rd(8'h14, "R6");

        // random mix, checked against the model
        for (int i = 0; i < 5000; i++) begin
            int unsigned r;
            logic w, rr, tk;
            logic [7:0] a;
            logic [31:0] d;
            r  = $urandom_range(0, 99);
            w  = (r < 12);
            rr = ($urandom_range(0, 99) < 35);
            tk = ($urandom_range(0, 99) < 75);
            a  = addrs[$urandom_range(0, 6)];
            d  = ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom();
            if (w && a == 8'h00 && $urandom_range(0, 1) == 1) d = m_cnt + 32'($urandom_range(1, 20));
            step(w, rr, a, d, tk, "R2");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule